// File: doc/BRIEF.md
# Management-Port PHY Register Responder

This block answers serial management frames as a 10/100 Ethernet PHY would. It samples the management clock and data pins using the chip's system clock. It decodes each frame, which is made of a preamble, a start pattern, an opcode, a 5-bit PHY address, a 5-bit register address, a two-bit turnaround and a 16-bit data field. It then either stores the write data or drives the read data back onto the shared data line.

The block holds thirty-two 16-bit registers. Most of them are plain storage that resets to fixed values. The status, link-partner, vendor and diagnostic registers are not stored. They are computed on every read from the `link_up` input and from the local advertisement register. As a result, negotiation always appears to have succeeded at the best mode that is advertised.

Only frames sent to the configured PHY address are answered. For any other address the line stays released, so the station reads all ones through the bus pull-up. The pins carry no handshake: the management clock paces every transfer, so no valid/ready pair exists and there is no back-pressure.

Top module: `mgmt_phy_responder`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 (advertisement) reads 0x01E1.
- R2: Register 1 reads 0x782E while `link_up` is high (bits 14, 13, 12, 11, 5, 3, 2 and 1 set) and reads 0x0000 while it is low.
- R3: Register 5 reads 0x4000, ORed with register 4 masked to bits 8..5, ORed with 0x0001.
- R4: Register 17 always reads 0x8000, even after it has been written.
- R5: While the link is down, register 18 reads 0. While the link is up, register 18 has bit 10 set when register 4 has bit 7 or bit 8 set, and bit 11 set when register 4 has bit 8 or bit 6 set. All its other bits are 0.
- R6: A write stores all 16 data bits in the addressed register, and a later read of that register returns them. Writes to the computed registers 1, 5, 17 and 18 do not change what those registers read.
- R7: Opcode 01 is a write and opcode 10 is a read, with both opcode bits sent MSB first. A frame with opcode 00 or 11 stores nothing and never drives the line.
- R8: On a read, `mdio_oe` rises only for the second turnaround bit, which is driven as 0, and for the 16 data bits, which are sent MSB first. Each driven value changes right after the rising management-clock edge that samples the previous bit. The line is released after the last data bit.
- R9: A start pattern 0 then 1 is accepted only after at least 32 consecutive ones. With a shorter preamble the whole frame is ignored.
- R10: A frame whose PHY address differs from the `PHY_ADDR` parameter (default 7) never drives the line, so a read returns 0xFFFF through the pull-up. A write to such an address is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the management pins |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Emulated link state used by the computed registers |
| mdc | input | 1 | Management clock from the station; each rising edge samples a bit |
| mdio_in | input | 1 | Data line as seen at the pin |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line; low means released |

## Verification
A decoder that has slipped by a bit shows up within the same frame. The turnaround pattern moves away from released-then-zero, or the count of driven bits differs from 17, or the read word comes back shifted. A corrupted register, or a wrong computed-value equation, shows on the very next read of that register. A preamble counter that does not reset, or an address filter that fails to block, shows up one frame later, as a stored value that should have stayed unchanged or as a driven bit where the line should have stayed released.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int PHY_AW = 5;

  typedef enum logic [2:0] {
    FR_PRE, FR_SOF, FR_OPC, FR_PHY, FR_REG, FR_TA, FR_DATA
  } frame_st_t;

  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;

  localparam int IDX_STATUS  = 1;
  localparam int IDX_ADV     = 4;
  localparam int IDX_PARTNER = 5;
  localparam int IDX_VENDOR  = 17;
  localparam int IDX_DIAG    = 18;

  localparam logic [15:0] STATUS_UP    = 16'h782E;
  localparam logic [15:0] PARTNER_BASE = 16'h4001;
  localparam logic [15:0] ADV_MODES    = 16'h01E0;
  localparam logic [15:0] VENDOR_VAL   = 16'h8000;

  function automatic logic [15:0] reg_reset_val(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mdio_frame_dec.sv
module mdio_frame_dec
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 7,
  parameter int PRE_LEN  = 32,
  parameter int DW       = 16,
  parameter int AW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bit_in,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] reg_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          mdio_out,
  output logic          mdio_oe
);
  localparam int CMAX = (PRE_LEN > DW) ? PRE_LEN : DW;
  localparam int CW   = $clog2(CMAX + 1);

  frame_st_t         st;
  logic [CW-1:0]     cnt;
  logic [1:0]        op_q;
  logic [PHY_AW-1:0] phy_q;
  logic [AW-1:0]     reg_q;
  logic [DW-1:0]     sh;
  logic              addr_hit, rd_go, wr_go;

  assign addr_hit = (phy_q == PHY_AW'(PHY_ADDR));
  assign rd_go    = addr_hit && (op_q == OPC_READ);
  assign wr_go    = addr_hit && (op_q == OPC_WRITE);
  assign reg_addr = reg_q;
  assign wr_data  = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= FR_PRE;
      cnt      <= '0;
      op_q     <= '0;
      phy_q    <= '0;
      reg_q    <= '0;
      sh       <= '0;
      wr_en    <= 1'b0;
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b1;
    end else begin
      wr_en <= 1'b0;
      if (tick) begin
        case (st)
          FR_PRE: begin
            if (bit_in) begin
              if (cnt != CW'(PRE_LEN)) cnt <= cnt + 1'b1;
            end else if (cnt == CW'(PRE_LEN)) begin
              st  <= FR_SOF;
              cnt <= '0;
            end else begin
              cnt <= '0;
            end
          end
          FR_SOF: begin
            st  <= bit_in ? FR_OPC : FR_PRE;
            cnt <= '0;
          end
          FR_OPC: begin
            op_q <= {op_q[0], bit_in};
            if (cnt == CW'(1)) begin st <= FR_PHY; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          FR_PHY: begin
            phy_q <= {phy_q[PHY_AW-2:0], bit_in};
            if (cnt == CW'(PHY_AW-1)) begin st <= FR_REG; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          FR_REG: begin
            reg_q <= {reg_q[AW-2:0], bit_in};
            if (cnt == CW'(AW-1)) begin st <= FR_TA; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          FR_TA: begin
            if (cnt == '0) begin
              cnt <= CW'(1);
              if (rd_go) begin
                mdio_oe  <= 1'b1;
                mdio_out <= 1'b0;
              end
            end else begin
              st  <= FR_DATA;
              cnt <= '0;
              if (rd_go) begin
                mdio_out <= rd_data[DW-1];
                sh       <= {rd_data[DW-2:0], 1'b0};
              end
            end
          end
          FR_DATA: begin
            if (rd_go) begin
              mdio_out <= sh[DW-1];
              sh       <= {sh[DW-2:0], 1'b0};
            end else begin
              sh <= {sh[DW-2:0], bit_in};
            end
            if (cnt == CW'(DW-1)) begin
              st       <= FR_PRE;
              cnt      <= '0;
              mdio_oe  <= 1'b0;
              mdio_out <= 1'b1;
              wr_en    <= wr_go;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            st  <= FR_PRE;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_PRE) |-> (cnt <= CW'(PRE_LEN))); // R9
  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (st == FR_TA || st == FR_DATA)); // R8
  AST_TA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && st == FR_TA) |-> !mdio_out); // R8
  AST_NO_FOREIGN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (phy_q == PHY_AW'(PHY_ADDR) && op_q == OPC_READ)); // R10
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R7
  AST_WR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (st == FR_PRE && !mdio_oe)); // R7

endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 16,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] adv;
  logic          diag_spd, diag_dup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= DW'(reg_reset_val(i));
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign adv      = mem[IDX_ADV];
  assign diag_spd = adv[7] | adv[8];
  assign diag_dup = adv[8] | adv[6];

  always_comb begin
    case (addr)
      AW'(IDX_STATUS):  rd_data = link_up ? DW'(STATUS_UP) : '0;
      AW'(IDX_PARTNER): rd_data = DW'(PARTNER_BASE) | (adv & DW'(ADV_MODES));
      AW'(IDX_VENDOR):  rd_data = DW'(VENDOR_VAL);
      AW'(IDX_DIAG): begin
        rd_data     = '0;
        rd_data[10] = link_up & diag_spd;
        rd_data[11] = link_up & diag_dup;
      end
      default:          rd_data = mem[addr];
    endcase
  end

  AST_VENDOR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(IDX_VENDOR)) |=> (rd_data == DW'(VENDOR_VAL) || addr != AW'(IDX_VENDOR))); // R4

endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder #(
  parameter int PHY_ADDR = 7,
  parameter int PRE_LEN  = 32,
  parameter int NREG     = 32,
  parameter int DW       = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic mdc,
  input  logic mdio_in,
  output logic mdio_out,
  output logic mdio_oe
);
  localparam int AW = $clog2(NREG);

  logic          mdc_q, tick;
  logic          wr_en;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] wr_data, rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc;
  end
  assign tick = mdc & ~mdc_q;

  mdio_frame_dec #(
    .PHY_ADDR(PHY_ADDR), .PRE_LEN(PRE_LEN), .DW(DW), .AW(AW)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_in(mdio_in),
    .rd_data(rd_data), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  phy_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .wr_en(wr_en),
    .addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  AST_OE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(tick)); // R8

endmodule

// File: tb/sim_mgmt_phy_responder.sv
module sim_mgmt_phy_responder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  logic clk = 1'b0, rst_n = 1'b0, link_up = 1'b1, mdc = 1'b0, mdio_in = 1'b1;
  logic mdio_out, mdio_oe;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_phy_responder u0 (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .mdc(mdc),
    .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  // {req[3:0], is_write, reg[4:0], data_or_expected[15:0]}
  localparam logic [25:0] VEC [NV] = '{
    {4'd1, 1'b0, 5'd0,  16'h3100},  // R1
    {4'd1, 1'b0, 5'd2,  16'h0300},  // R1
    {4'd1, 1'b0, 5'd3,  16'hE400},  // R1
    {4'd1, 1'b0, 5'd4,  16'h01E1},  // R1
    {4'd2, 1'b0, 5'd1,  16'h782E},  // R2
    {4'd3, 1'b0, 5'd5,  16'h41E1},  // R3
    {4'd4, 1'b0, 5'd17, 16'h8000},  // R4
    {4'd5, 1'b0, 5'd18, 16'h0C00},  // R5
    {4'd6, 1'b1, 5'd4,  16'h0041},  // R6
    {4'd6, 1'b0, 5'd4,  16'h0041},  // R6
    {4'd5, 1'b0, 5'd18, 16'h0800},  // R5
    {4'd3, 1'b0, 5'd5,  16'h4041},  // R3
    {4'd6, 1'b1, 5'd4,  16'h0081},  // R6
    {4'd5, 1'b0, 5'd18, 16'h0400},  // R5
    {4'd3, 1'b0, 5'd5,  16'h4081},  // R3
    {4'd6, 1'b1, 5'd4,  16'h0021},  // R6
    {4'd5, 1'b0, 5'd18, 16'h0000},  // R5
    {4'd4, 1'b1, 5'd17, 16'h1234},  // R4
    {4'd4, 1'b0, 5'd17, 16'h8000},  // R4
    {4'd6, 1'b1, 5'd1,  16'h0000},  // R6
    {4'd6, 1'b0, 5'd1,  16'h782E},  // R6
    {4'd6, 1'b1, 5'd9,  16'hA5C3},  // R6
    {4'd6, 1'b0, 5'd9,  16'hA5C3},  // R6
    {4'd6, 1'b1, 5'd31, 16'hFFFF}   // R6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic obs, output logic oe);
    mdio_in = b;
    mdc     = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    obs = mdio_oe ? mdio_out : 1'b1;
    oe  = mdio_oe;
    mdc = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output logic [1:0] ta, output int oe_n);
    logic o, e;
    logic [31:0] hdr;
    oe_n = 0;
    rd   = '0;
    for (int i = 0; i < pre; i++) begin send_bit(1'b1, o, e); oe_n += int'(e); end
    hdr = {18'b0, 2'b01, op, pa, ra};
    for (int i = 13; i >= 0; i--) begin send_bit(hdr[i], o, e); oe_n += int'(e); end
    send_bit(1'b1, o, e); ta[1] = o; oe_n += int'(e);
    send_bit((op == 2'b10) ? 1'b1 : 1'b0, o, e); ta[0] = o; oe_n += int'(e);
    for (int i = 15; i >= 0; i--) begin
      send_bit((op == 2'b10) ? 1'b1 : wd[i], o, e);
      rd[i] = o;
      oe_n += int'(e);
    end
    send_bit(1'b0, o, e); oe_n += int'(e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    logic [1:0]  ta;
    int          oe_n;
    repeat (4) @(posedge clk);
    #1;
    check("R8 reset release", {15'b0, mdio_oe}, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    for (int v = 0; v < NV; v++) begin
      logic [3:0]  rq;
      logic        w;
      logic [4:0]  ra;
      logic [15:0] d;
      string       tag;
      {rq, w, ra, d} = VEC[v];
      tag = $sformatf("R%0d vec%0d", rq, v);
      if (w) begin
        frame(32, 2'b01, 5'd7, ra, d, rd, ta, oe_n);
        check({tag, " R7 write no drive"}, 16'(oe_n), 16'd0);
      end else begin
        frame(32, 2'b10, 5'd7, ra, 16'h0, rd, ta, oe_n);
        check(tag, rd, d);
        check({tag, " R8 drive window"}, {6'b0, ta, 8'(oe_n)}, {6'b0, 2'b10, 8'd17});
      end
    end
    frame(32, 2'b10, 5'd7, 5'd31, 16'h0, rd, ta, oe_n);
    check("R6 reg31 all ones", rd, 16'hFFFF);

    // R2 and R5 with link down
    link_up = 1'b0;
    frame(32, 2'b10, 5'd7, 5'd1, 16'h0, rd, ta, oe_n);
    check("R2 link down", rd, 16'h0000);
    frame(32, 2'b10, 5'd7, 5'd18, 16'h0, rd, ta, oe_n);
    check("R5 link down", rd, 16'h0000);
    link_up = 1'b1;

    // R10 foreign address
    frame(32, 2'b01, 5'd3, 5'd9, 16'h1111, rd, ta, oe_n);
    check("R10 foreign write no drive", 16'(oe_n), 16'd0);
    frame(32, 2'b10, 5'd3, 5'd9, 16'h0, rd, ta, oe_n);
    check("R10 foreign read", rd, 16'hFFFF);
    check("R10 foreign read no drive", 16'(oe_n), 16'd0);
    frame(32, 2'b10, 5'd7, 5'd9, 16'h0, rd, ta, oe_n);
    check("R10 foreign write ignored", rd, 16'hA5C3);

    // R9 preamble length
    frame(31, 2'b01, 5'd7, 5'd9, 16'h2222, rd, ta, oe_n);
    frame(32, 2'b10, 5'd7, 5'd9, 16'h0, rd, ta, oe_n);
    check("R9 short preamble ignored", rd, 16'hA5C3);
    frame(31, 2'b10, 5'd7, 5'd0, 16'h0, rd, ta, oe_n);
    check("R9 short preamble no drive", 16'(oe_n), 16'd0);
    frame(40, 2'b10, 5'd7, 5'd2, 16'h0, rd, ta, oe_n);
    check("R9 long preamble accepted", rd, 16'h0300);

    // R7 invalid opcodes
    frame(32, 2'b00, 5'd7, 5'd9, 16'h3333, rd, ta, oe_n);
    check("R7 op00 no drive", 16'(oe_n), 16'd0);
    frame(32, 2'b11, 5'd7, 5'd9, 16'h4444, rd, ta, oe_n);
    check("R7 op11 no drive", 16'(oe_n), 16'd0);
    frame(32, 2'b10, 5'd7, 5'd9, 16'h0, rd, ta, oe_n);
    check("R7 invalid ops store nothing", rd, 16'hA5C3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule